// File: doc/BRIEF.md
# External Trigger Clock Conditioner

This block turns an asynchronous trigger line into a clean count enable for a timer's up-counter. One of sixteen trigger lines is picked by an index. The chosen line may be inverted so that falling edges count. It then passes through a free-running divider clocked by the trigger itself. The divider works before any resynchronisation, so a fast trigger can be slowed below the rate that the kernel clock can sample.

The divided signal crosses into the kernel clock domain through a two-flop synchroniser. An optional glitch filter follows. It is a small state machine with two states. In `FLT_SETTLED` the output matches the input. When the synchronised input disagrees with the output, the filter loads a down-counter and moves to `FLT_QUALIFY`. In `FLT_QUALIFY`, three things can happen:
- If the input returns to the output level, the filter goes back to `FLT_SETTLED` and discards the count (bounce).
- If the counter reaches zero, the output takes the new level and the filter returns to `FLT_SETTLED` (accept).
- Otherwise the counter decrements.

A filter code of zero bypasses the state machine. The filtered level is exported as the conditioned trigger. Its rising edges advance the counter by one, but only while both the external-clock-mode enable and the counter enable are set. The counter wraps to zero with a one-cycle overflow flag.

Top module: `ext_trig_clk_cond`

## Requirements
- R1: The line `trig_in[src_sel]` is the only trigger source; activity on every other line leaves the counter and `cond_trig_o` unchanged.
- R2: With `pol_inv` = 0, rising edges of the selected line count. With `pol_inv` = 1, falling edges count and rising edges do not.
- R3: `psc_code` selects the divide ratio D: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8. After the divider is cleared, N qualifying edges, with N a multiple of D, advance the counter by N/D.
- R4: Any change of `psc_code` or `pol_inv` clears the divider on the following kernel cycle. After a clear with D = 4, two qualifying edges advance the counter by one.
- R5: With the filter bypassed, an input edge that occurs between kernel edges shows on `cond_trig_o` after the second kernel edge and on `count_o` after the third.
- R6: With a non-zero `flt_code` N, `cond_trig_o` takes a new level only after 2^N consecutive kernel samples of that level, the first taken on the third kernel edge after the input change. Shorter pulses are dropped.
- R7: The counter advances only while `ext_clk_en` and `cnt_en` are both 1. If either is 0, it holds its value.
- R8: Each counted edge adds exactly one. The counter wraps from all ones to zero, and `ovf_o` is high for exactly that one cycle.
- R9: After reset, `count_o`, `ovf_o` and `cond_trig_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | 2^SEL_W | Candidate trigger lines, asynchronous |
| src_sel | input | SEL_W | Index of the line to use |
| pol_inv | input | 1 | 1 inverts the line (falling edges count) |
| psc_code | input | 2 | Divider code, ratio 2^code |
| flt_code | input | 4 | Filter code, 0 bypasses |
| ext_clk_en | input | 1 | External-clock-mode enable |
| cnt_en | input | 1 | Counter enable |
| count_o | output | CNT_W | Counter value |
| ovf_o | output | 1 | One-cycle wrap flag |
| cond_trig_o | output | 1 | Filtered, synchronised trigger level |

## Verification
The assertions assume that the divided trigger changes no faster than once every two kernel cycles. This means each level is sampled at least twice, so no edge is lost in the synchroniser. The stimulus holds every level of the selected line for at least one kernel cycle before division, and for at least two cycles when the divider ratio is 1. The filter assertion also assumes the filter code stays non-zero across the cycle it checks. The bench therefore changes `flt_code`, `psc_code`, `src_sel` and `pol_inv` only while counting is disabled, then waits for the datapath to settle before it enables counting again.

// File: rtl/etc_pkg.sv
package etc_pkg;
    typedef enum logic {
        FLT_SETTLED,
        FLT_QUALIFY
    } flt_state_e;

    localparam int PSC_CODE_W = 2;
    localparam int FLT_CODE_W = 4;
endpackage

// File: rtl/etc_prescaler.sv
module etc_prescaler #(
    parameter int PSC_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sig_i,
    input  logic [PSC_W-1:0] psc_code,
    input  logic             pol_inv,
    output logic             div_o
);
    localparam int DIV_BITS = (1 << PSC_W) - 1;

    logic [PSC_W:0]    cfg_q;
    logic              clr_q;
    logic [DIV_BITS-1:0] div_cnt;

    // Kernel-domain change detector; clear held high through reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
            clr_q <= 1'b1;
        end else begin
            cfg_q <= {pol_inv, psc_code};
            clr_q <= ({pol_inv, psc_code} != cfg_q);
        end
    end

    // Divider clocked by the trigger itself.
    always_ff @(posedge sig_i or posedge clr_q) begin
        if (clr_q) div_cnt <= '0;
        else       div_cnt <= div_cnt + 1'b1;
    end

    always_comb begin
        div_o = sig_i;
        for (int k = 1; k <= DIV_BITS; k++) begin
            if (psc_code == PSC_W'(k)) div_o = div_cnt[k-1];
        end
    end
endmodule

// File: rtl/etc_sync.sv
module etc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] stg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= {stg_q[STAGES-2:0], async_i};
    end

    assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/etc_filter.sv
module etc_filter
    import etc_pkg::*;
#(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_i,
    input  logic [CODE_W-1:0] flt_code,
    output logic              filt_o
);
    localparam int DC_W = (1 << CODE_W) - 1;

    flt_state_e      state_q, state_d;
    logic [DC_W-1:0] dcnt_q, dcnt_d;
    logic            filt_q, filt_d;
    logic [DC_W:0]   span;
    logic [DC_W-1:0] load_val;

    // 2^N samples: one in FLT_SETTLED, 2^N-1 in FLT_QUALIFY.
    assign span     = (DC_W+1)'(1) << flt_code;
    assign load_val = DC_W'(span - (DC_W+1)'(2));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLT_SETTLED;
            dcnt_q  <= '0;
            filt_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            dcnt_q  <= dcnt_d;
            filt_q  <= filt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        dcnt_d  = dcnt_q;
        filt_d  = filt_q;
        if (flt_code == '0) begin
            state_d = FLT_SETTLED;
            filt_d  = sync_i;
        end else begin
            unique case (state_q)
                FLT_SETTLED: begin
                    if (sync_i != filt_q) begin
                        state_d = FLT_QUALIFY;
                        dcnt_d  = load_val;
                    end
                end
                FLT_QUALIFY: begin
                    if (sync_i == filt_q) begin
                        state_d = FLT_SETTLED;
                    end else if (dcnt_q == '0) begin
                        filt_d  = sync_i;
                        state_d = FLT_SETTLED;
                    end else begin
                        dcnt_d = dcnt_q - 1'b1;
                    end
                end
            endcase
        end
    end

    assign filt_o = (flt_code == '0) ? sync_i : filt_q;

    // R6: an input that agrees with the output never moves it.
    a_r6_bounce_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_code != '0 && sync_i == filt_o) |=> (flt_code == '0 || $stable(filt_o)));
endmodule

// File: rtl/etc_edge_counter.sv
module etc_edge_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_i,
    input  logic             gate_i,
    output logic [CNT_W-1:0] count_o,
    output logic             ovf_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic trig_q;
    logic pulse;
    logic inc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trig_q <= 1'b0;
        else        trig_q <= trig_i;
    end

    assign pulse = trig_i & ~trig_q;
    assign inc   = pulse & gate_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_o <= '0;
            ovf_o   <= 1'b0;
        end else begin
            ovf_o <= inc && (count_o == CNT_MAX);
            if (inc) count_o <= count_o + 1'b1;
        end
    end

    a_r5_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);
    a_r7_gate_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_i |=> $stable(count_o));
    a_r8_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        inc |=> (count_o == CNT_W'($past(count_o) + 1'b1)));
    a_r8_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> (count_o == '0));
    a_r8_ovf_single: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> !ovf_o);
endmodule

// File: rtl/ext_trig_clk_cond.sv
module ext_trig_clk_cond
    import etc_pkg::*;
#(
    parameter int SEL_W = 4,
    parameter int CNT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [(1<<SEL_W)-1:0]   trig_in,
    input  logic [SEL_W-1:0]        src_sel,
    input  logic                    pol_inv,
    input  logic [PSC_CODE_W-1:0]   psc_code,
    input  logic [FLT_CODE_W-1:0]   flt_code,
    input  logic                    ext_clk_en,
    input  logic                    cnt_en,
    output logic [CNT_W-1:0]        count_o,
    output logic                    ovf_o,
    output logic                    cond_trig_o
);
    logic sel_line;
    logic sig_pol;
    logic div_sig;
    logic sync_sig;

    assign sel_line = trig_in[src_sel];
    assign sig_pol  = sel_line ^ pol_inv;

    etc_prescaler #(.PSC_W(PSC_CODE_W)) u_psc (
        .clk      (clk),
        .rst_n    (rst_n),
        .sig_i    (sig_pol),
        .psc_code (psc_code),
        .pol_inv  (pol_inv),
        .div_o    (div_sig)
    );

    etc_sync #(.STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (div_sig),
        .sync_o  (sync_sig)
    );

    etc_filter #(.CODE_W(FLT_CODE_W)) u_flt (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_i   (sync_sig),
        .flt_code (flt_code),
        .filt_o   (cond_trig_o)
    );

    etc_edge_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig_i  (cond_trig_o),
        .gate_i  (ext_clk_en & cnt_en),
        .count_o (count_o),
        .ovf_o   (ovf_o)
    );
endmodule

// File: tb/ext_trig_clk_cond_bench.sv
module ext_trig_clk_cond_bench;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [15:0]   trig_in = '0;
    logic [3:0]    src_sel = '0;
    logic          pol_inv = 1'b0;
    logic [1:0]    psc_code = '0;
    logic [3:0]    flt_code = '0;
    logic          ext_clk_en = 1'b0;
    logic          cnt_en = 1'b0;
    logic [CW-1:0] count_o;
    logic          ovf_o;
    logic          cond_trig_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ext_trig_clk_cond #(.SEL_W(4), .CNT_W(CW)) u_ext_trig_clk_cond (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .src_sel(src_sel),
        .pol_inv(pol_inv), .psc_code(psc_code), .flt_code(flt_code),
        .ext_clk_en(ext_clk_en), .cnt_en(cnt_en),
        .count_o(count_o), .ovf_o(ovf_o), .cond_trig_o(cond_trig_o)
    );

    typedef struct packed {
        logic [3:0] src;
        logic       pol;
        logic [1:0] psc;
        logic [3:0] flt;
        logic [7:0] nedge;
        logic [3:0] hp;
        logic [7:0] expd;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{4'd0,  1'b0, 2'd0, 4'd0, 8'd5,  4'd3, 8'd5},  // R3 /1, R2 rising
        '{4'd0,  1'b1, 2'd0, 4'd0, 8'd4,  4'd3, 8'd4},  // R2 falling
        '{4'd5,  1'b0, 2'd1, 4'd0, 8'd6,  4'd1, 8'd3},  // R3 /2, R1 line 5
        '{4'd15, 1'b0, 2'd2, 4'd0, 8'd8,  4'd1, 8'd2},  // R3 /4
        '{4'd3,  1'b1, 2'd3, 4'd0, 8'd16, 4'd1, 8'd2},  // R3 /8
        '{4'd7,  1'b0, 2'd0, 4'd2, 8'd3,  4'd6, 8'd3},  // R6 long levels pass
        '{4'd7,  1'b0, 2'd0, 4'd2, 8'd3,  4'd2, 8'd0},  // R6 short pulses dropped
        '{4'd9,  1'b0, 2'd1, 4'd1, 8'd4,  4'd3, 8'd2}   // R3 with R6 filter
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic setup(input logic [3:0] src, input logic pol,
                         input logic [1:0] psc, input logic [3:0] flt);
        @(negedge clk);
        cnt_en   = 1'b0;
        trig_in  = {16{pol}};
        src_sel  = src;
        pol_inv  = pol;
        psc_code = psc;
        flt_code = flt;
        cyc(24);
    endtask

    task automatic pulses(input int idx, input logic pol, input int n, input int hp);
        for (int i = 0; i < n; i++) begin
            trig_in[idx] = ~pol;
            cyc(hp);
            trig_in[idx] = pol;
            cyc(hp);
        end
    endtask

    initial begin
        logic [CW-1:0] c0;
        int ovf_cnt;
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        chk("R9 count", count_o, 0);
        chk("R9 ovf", ovf_o, 0);
        chk("R9 cond", cond_trig_o, 0);

        for (int v = 0; v < 8; v++) begin
            setup(VECS[v].src, VECS[v].pol, VECS[v].psc, VECS[v].flt);
            ext_clk_en = 1'b1;
            cnt_en = 1'b1;
            c0 = count_o;
            pulses(VECS[v].src, VECS[v].pol, VECS[v].nedge, VECS[v].hp);
            cyc(20);
            chk($sformatf("R3 table row %0d", v), CW'(count_o - c0), VECS[v].expd);
        end

        // R1: other lines ignored
        setup(4'd2, 1'b0, 2'd0, 4'd0);
        ext_clk_en = 1'b1; cnt_en = 1'b1;
        c0 = count_o;
        pulses(3, 1'b0, 4, 3);
        cyc(10);
        chk("R1 unselected line", CW'(count_o - c0), 0);
        chk("R1 cond idle", cond_trig_o, 0);
        pulses(2, 1'b0, 2, 3);
        cyc(10);
        chk("R1 selected line", CW'(count_o - c0), 2);

        // R5: bypass latency
        setup(4'd0, 1'b0, 2'd0, 4'd0);
        ext_clk_en = 1'b1; cnt_en = 1'b1;
        c0 = count_o;
        trig_in[0] = 1'b1;
        cyc(1);
        chk("R5 cond after 1 edge", cond_trig_o, 0);
        cyc(1);
        chk("R5 cond after 2 edges", cond_trig_o, 1);
        chk("R5 count after 2 edges", CW'(count_o - c0), 0);
        cyc(1);
        chk("R5 count after 3 edges", CW'(count_o - c0), 1);
        trig_in[0] = 1'b0;
        cyc(10);

        // R2: falling edge counts with inversion, rising does not
        setup(4'd1, 1'b1, 2'd0, 4'd0);
        ext_clk_en = 1'b1; cnt_en = 1'b1;
        c0 = count_o;
        trig_in[1] = 1'b0;
        cyc(3);
        chk("R2 falling edge counted", CW'(count_o - c0), 1);
        trig_in[1] = 1'b1;
        cyc(6);
        chk("R2 rising edge ignored", CW'(count_o - c0), 1);

        // R6: filter latency, code 2 -> 4 samples
        setup(4'd0, 1'b0, 2'd0, 4'd2);
        trig_in[0] = 1'b1;
        cyc(5);
        chk("R6 cond before 4 samples", cond_trig_o, 0);
        cyc(1);
        chk("R6 cond after 4 samples", cond_trig_o, 1);
        trig_in[0] = 1'b0;
        cyc(10);

        // R7: gating
        setup(4'd0, 1'b0, 2'd0, 4'd0);
        ext_clk_en = 1'b0; cnt_en = 1'b1;
        c0 = count_o;
        pulses(0, 1'b0, 3, 3);
        cyc(6);
        chk("R7 mode enable low", CW'(count_o - c0), 0);
        ext_clk_en = 1'b1; cnt_en = 1'b0;
        pulses(0, 1'b0, 3, 3);
        cyc(6);
        chk("R7 counter enable low", CW'(count_o - c0), 0);

        // R4: divider clear on code change
        setup(4'd0, 1'b0, 2'd2, 4'd0);
        ext_clk_en = 1'b1; cnt_en = 1'b1;
        c0 = count_o;
        pulses(0, 1'b0, 2, 2);
        cyc(8);
        chk("R4 two edges at /4", CW'(count_o - c0), 1);
        setup(4'd0, 1'b0, 2'd3, 4'd0);
        setup(4'd0, 1'b0, 2'd2, 4'd0);
        cnt_en = 1'b1;
        c0 = count_o;
        pulses(0, 1'b0, 2, 2);
        cyc(8);
        chk("R4 two edges after clear", CW'(count_o - c0), 1);

        // R8: wrap and overflow
        setup(4'd0, 1'b0, 2'd0, 4'd0);
        ext_clk_en = 1'b1; cnt_en = 1'b1;
        c0 = count_o;
        pulses(0, 1'b0, 255 - int'(c0), 2);
        cyc(8);
        chk("R8 reach all ones", count_o, 255);
        chk("R8 no early ovf", ovf_o, 0);
        ovf_cnt = 0;
        trig_in[0] = 1'b1;
        for (int i = 0; i < 10; i++) begin
            cyc(1);
            if (ovf_o) ovf_cnt++;
        end
        trig_in[0] = 1'b0;
        chk("R8 wrap to zero", count_o, 0);
        chk("R8 ovf one cycle", ovf_cnt, 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule